// File: doc/BRIEF.md
# Channel-Steered Tuning Word Register Bank

This block holds the frequency and phase control words of a two-channel waveform generator. Both channels are reached through one frequency address and one phase address. A channel-select register picks which channels a write to those shared addresses goes to. With it, one write can load every channel at once, or software can load each channel separately by enabling one channel at a time.

Each word is kept twice per channel. A write goes into a staging copy. The staging copy moves to the active copy, which drives the outputs, only when the update strobe is pulsed. All channels take their new values on the same clock edge, so a frequency or phase change is coherent across channels.

The channel-select register is not staged: a new value steers the next write straight away. A parallel read port returns the staging contents, so software can check what is waiting before it issues an update.

Top module: `chbank_top`

## Requirements
- R1: After reset every channel enable bit is 1, every staged and active frequency and phase word is 0, and `rdata_o` is 0.
- R2: A write to address 0x00 loads `wdata_i[NUM_CH-1:0]` into the enable bits, where bit c enables channel c. The new enables steer the very next write, with no update strobe. A read of 0x00 returns the enable bits zero-extended.
- R3: A write to address 0x04 stores `wdata_i[31:0]` into the staged frequency word of every enabled channel. A disabled channel keeps its staged frequency word.
- R4: A write to address 0x05 stores `wdata_i[13:0]` into the staged phase word of every enabled channel. The upper data bits are ignored, and a disabled channel keeps its staged phase word.
- R5: `freq_o` and `phase_o` do not change unless `upd_i` is high. When `upd_i` is high, every channel copies its staged words to its active words on the same edge. Channel c drives `freq_o[c*32 +: 32]` and `phase_o[c*14 +: 14]`.
- R6: When a write and `upd_i` fall in the same cycle, the update transfers the staged values from before that write. The written data stays staged until the next update.
- R7: A write to 0x04 or 0x05 while no channel is enabled changes no staged word.
- R8: A read (`rd_i`) returns its data on `rdata_o` one cycle later. At 0x04 or 0x05 it returns the staged word of the lowest-numbered enabled channel, zero-extended. With no channel enabled, or at any other address, it returns 0.
- R9: Enabling channels one at a time, writing each channel's words and then pulsing one update makes each channel output its own values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 32 | Write data |
| upd_i | input | 1 | Update strobe: staged words to active |
| rdata_o | output | 32 | Read data, valid the cycle after `rd_i` |
| freq_o | output | 64 | Active frequency words, channel c at bits [c*32 +: 32] |
| phase_o | output | 28 | Active phase words, channel c at bits [c*14 +: 14] |

## Verification
A wrong enable state or a wrong staged word shows up on `rdata_o` one cycle after a read of a shared address, because the read reports the lowest enabled channel. A fault in the staging path shows up on `freq_o` and `phase_o` only one cycle after the next update, so the bench reads back after each write and checks the outputs after each update. Writes are steered to each channel in turn, writes are made with no channel enabled, and a write is issued in the same cycle as an update. Together these separate a fault that leaks across channels from a fault that only shows up at an update.

// File: rtl/chbank_pkg.sv
package chbank_pkg;
  localparam int unsigned ADDR_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t ADDR_CHSEL = 8'h00;
  localparam addr_t ADDR_FREQ  = 8'h04;
  localparam addr_t ADDR_PHASE = 8'h05;

  typedef enum logic [1:0] {TGT_NONE, TGT_CHSEL, TGT_FREQ, TGT_PHASE} tgt_e;

  function automatic tgt_e decode_addr(addr_t a);
    case (a)
      ADDR_CHSEL: return TGT_CHSEL;
      ADDR_FREQ:  return TGT_FREQ;
      ADDR_PHASE: return TGT_PHASE;
      default:    return TGT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/chbank_sel.sv
module chbank_sel #(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [NUM_CH-1:0] d_i,
  output logic [NUM_CH-1:0] en_o
);
  // not double-buffered: steers the next write directly
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_o <= '1;
    else if (we_i) en_o <= d_i;
  end
endmodule

// File: rtl/chbank_slot.sv
module chbank_slot #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  input  logic         upd_i,
  output logic [W-1:0] stg_o,
  output logic [W-1:0] act_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_o <= '0;
    else if (ld_i) stg_o <= d_i;
  end

  // nonblocking: a same-cycle write is not seen by the transfer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_o <= '0;
    else if (upd_i) act_o <= stg_o;
  end
endmodule

// File: rtl/chbank_rdmux.sv
module chbank_rdmux
  import chbank_pkg::*;
#(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned FREQ_W  = 32,
  parameter int unsigned PHASE_W = 14,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rd_i,
  input  tgt_e                      tgt_i,
  input  logic [NUM_CH-1:0]         en_i,
  input  logic [NUM_CH*FREQ_W-1:0]  stg_freq_i,
  input  logic [NUM_CH*PHASE_W-1:0] stg_phase_i,
  output logic [DATA_W-1:0]         rdata_o
);
  logic [FREQ_W-1:0]  sel_f;
  logic [PHASE_W-1:0] sel_p;
  logic               any_en;
  logic [DATA_W-1:0]  rd_nxt;

  // lowest enabled channel wins
  always_comb begin
    sel_f  = '0;
    sel_p  = '0;
    any_en = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (en_i[c] && !any_en) begin
        sel_f  = stg_freq_i[c*FREQ_W +: FREQ_W];
        sel_p  = stg_phase_i[c*PHASE_W +: PHASE_W];
        any_en = 1'b1;
      end
    end
  end

  always_comb begin
    rd_nxt = '0;
    case (tgt_i)
      TGT_CHSEL: rd_nxt[NUM_CH-1:0]  = en_i;
      TGT_FREQ:  rd_nxt[FREQ_W-1:0]  = sel_f;
      TGT_PHASE: rd_nxt[PHASE_W-1:0] = sel_p;
      default:   rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_nxt;
  end
endmodule

// File: rtl/chbank_top.sv
module chbank_top
  import chbank_pkg::*;
#(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned FREQ_W  = 32,
  parameter int unsigned PHASE_W = 14,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic                      rd_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic                      upd_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic [NUM_CH*FREQ_W-1:0]  freq_o,
  output logic [NUM_CH*PHASE_W-1:0] phase_o
);
  tgt_e                      tgt;
  logic [NUM_CH-1:0]         chan_en;
  logic [NUM_CH*FREQ_W-1:0]  stg_freq;
  logic [NUM_CH*PHASE_W-1:0] stg_phase;

  assign tgt = decode_addr(addr_i);

  chbank_sel #(.NUM_CH(NUM_CH)) u_sel (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (wr_i && (tgt == TGT_CHSEL)),
    .d_i   (wdata_i[NUM_CH-1:0]),
    .en_o  (chan_en)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chbank_slot #(.W(FREQ_W)) u_freq (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ld_i  (wr_i && (tgt == TGT_FREQ) && chan_en[c]),
      .d_i   (wdata_i[FREQ_W-1:0]),
      .upd_i (upd_i),
      .stg_o (stg_freq[c*FREQ_W +: FREQ_W]),
      .act_o (freq_o[c*FREQ_W +: FREQ_W])
    );
    chbank_slot #(.W(PHASE_W)) u_phase (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ld_i  (wr_i && (tgt == TGT_PHASE) && chan_en[c]),
      .d_i   (wdata_i[PHASE_W-1:0]),
      .upd_i (upd_i),
      .stg_o (stg_phase[c*PHASE_W +: PHASE_W]),
      .act_o (phase_o[c*PHASE_W +: PHASE_W])
    );
  end

  chbank_rdmux #(
    .NUM_CH(NUM_CH), .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .DATA_W(DATA_W)
  ) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (rd_i),
    .tgt_i      (tgt),
    .en_i       (chan_en),
    .stg_freq_i (stg_freq),
    .stg_phase_i(stg_phase),
    .rdata_o    (rdata_o)
  );
endmodule

// File: rtl/chbank_chk.sv
module chbank_chk
  import chbank_pkg::*;
#(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned FREQ_W  = 32,
  parameter int unsigned PHASE_W = 14,
  parameter int unsigned DATA_W  = 32
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      wr_i,
  input logic                      rd_i,
  input logic [ADDR_W-1:0]         addr_i,
  input logic [DATA_W-1:0]         wdata_i,
  input logic                      upd_i,
  input logic [DATA_W-1:0]         rdata_o,
  input logic [NUM_CH*FREQ_W-1:0]  freq_o,
  input logic [NUM_CH*PHASE_W-1:0] phase_o,
  input logic [NUM_CH-1:0]         chan_en,
  input logic [NUM_CH*FREQ_W-1:0]  stg_freq,
  input logic [NUM_CH*PHASE_W-1:0] stg_phase
);
  // R5
  active_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> ($stable(freq_o) && $stable(phase_o)));

  // R6
  update_old_stage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (freq_o == $past(stg_freq) && phase_o == $past(stg_phase)));

  // R2
  chsel_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_CHSEL) |=> chan_en == $past(wdata_i[NUM_CH-1:0]));

  // R7
  no_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && chan_en == '0) |=> ($stable(stg_freq) && $stable(stg_phase)));

  // R8
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i != ADDR_CHSEL && addr_i != ADDR_FREQ && addr_i != ADDR_PHASE)
      |=> rdata_o == '0);
endmodule

bind chbank_top chbank_chk #(
  .NUM_CH(NUM_CH), .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .upd_i    (upd_i),
  .rdata_o  (rdata_o),
  .freq_o   (freq_o),
  .phase_o  (phase_o),
  .chan_en  (chan_en),
  .stg_freq (stg_freq),
  .stg_phase(stg_phase)
);

// File: tb/chbank_top_bench.sv
module chbank_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0, rd_i = 1'b0, upd_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [63:0] freq_o;
  logic [27:0] phase_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [NCH-1:0] m_en;
  logic [31:0]    m_sf[NCH], m_af[NCH];
  logic [13:0]    m_sp[NCH], m_ap[NCH];

  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t q[$];
  logic rd_d = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  chbank_top u_chbank_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .upd_i(upd_i),
    .rdata_o(rdata_o), .freq_o(freq_o), .phase_o(phase_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_outs(string tag);
    for (int c = 0; c < NCH; c++) begin
      check(tag, freq_o[c*32 +: 32], m_af[c]);
      check(tag, {18'd0, phase_o[c*14 +: 14]}, {18'd0, m_ap[c]});
    end
  endtask

  // driver: one cycle of stimulus; model follows requirements
  task automatic cyc(logic w, logic [7:0] a, logic [31:0] d, logic u);
    @(negedge clk_i);
    wr_i = w; addr_i = a; wdata_i = d; upd_i = u;
    if (u) for (int c = 0; c < NCH; c++) begin m_af[c] = m_sf[c]; m_ap[c] = m_sp[c]; end
    if (w) begin
      if (a == 8'h00) m_en = d[NCH-1:0];
      for (int c = 0; c < NCH; c++) begin
        if (a == 8'h04 && m_en[c]) m_sf[c] = d;
        if (a == 8'h05 && m_en[c]) m_sp[c] = d[13:0];
      end
    end
    @(negedge clk_i);
    wr_i = 0; upd_i = 0;
  endtask

  task automatic rd(logic [7:0] a, string tag);
    exp_t e;
    e.tag = tag;
    e.val = '0;
    if (a == 8'h00) e.val = {30'd0, m_en};
    else if (a == 8'h04 || a == 8'h05) begin
      for (int c = NCH-1; c >= 0; c--)
        if (m_en[c]) e.val = (a == 8'h04) ? m_sf[c] : {18'd0, m_sp[c]};
    end
    q.push_back(e);
    @(negedge clk_i);
    rd_i = 1; addr_i = a;
    @(negedge clk_i);
    rd_i = 0;
  endtask

  // monitor
  always @(posedge clk_i) rd_d <= rd_i;
  always @(negedge clk_i) if (rd_d) begin
    exp_t e;
    if (q.size() == 0) check("read with empty queue", rdata_o, 32'hx);
    else begin e = q.pop_front(); check(e.tag, rdata_o, e.val); end
  end

  initial begin
    m_en = '1;
    for (int c = 0; c < NCH; c++) begin m_sf[c] = 0; m_af[c] = 0; m_sp[c] = 0; m_ap[c] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check("R1 rdata reset", rdata_o, 32'd0);
    chk_outs("R1 outputs reset");
    rd(8'h00, "R1 enables reset");
    rd(8'h04, "R1 staged freq reset");
    rd(8'h05, "R1 staged phase reset");

    cyc(1, 8'h04, 32'h1234_5678, 0);
    chk_outs("R5 no change before update");
    rd(8'h04, "R3 broadcast freq");
    cyc(1, 8'h05, 32'hFFFF_3ABC, 0);
    rd(8'h05, "R4 phase low bits");
    cyc(0, 8'h00, 32'h0, 1);
    chk_outs("R5 update all channels");

    cyc(1, 8'h00, 32'h1, 0);
    rd(8'h00, "R2 enable readback");
    cyc(1, 8'h04, 32'hAAAA_0001, 0);
    cyc(1, 8'h05, 32'h0000_0111, 0);
    cyc(1, 8'h00, 32'h2, 0);
    cyc(1, 8'h04, 32'hBBBB_0002, 0);
    cyc(1, 8'h05, 32'h0000_2222, 0);
    rd(8'h04, "R8 lowest enabled is ch1");
    cyc(1, 8'h00, 32'h3, 0);
    rd(8'h04, "R3 ch0 kept while disabled");
    chk_outs("R5 held before update");
    cyc(0, 8'h00, 32'h0, 1);
    chk_outs("R9 per-channel values");

    cyc(1, 8'h00, 32'h0, 0);
    cyc(1, 8'h04, 32'hDEAD_BEEF, 0);
    cyc(1, 8'h05, 32'h0000_0F0F, 0);
    rd(8'h04, "R8 no channel enabled");
    cyc(0, 8'h00, 32'h0, 1);
    chk_outs("R7 discarded write");
    cyc(1, 8'h00, 32'h3, 0);
    rd(8'h04, "R7 ch0 freq untouched");
    rd(8'h05, "R7 ch0 phase untouched");

    cyc(1, 8'h04, 32'hC0C0_C0C0, 1);
    chk_outs("R6 update uses pre-write stage");
    cyc(0, 8'h00, 32'h0, 1);
    chk_outs("R6 new data at next update");

    rd(8'h07, "R8 unmapped read");
    rd(8'h01, "R8 unmapped read 2");
    repeat (3) @(negedge clk_i);
    check("R8 all reads seen", q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule